// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level table held in memory. The top ten bits of the linear address pick a directory entry, the next ten bits pick an entry in the page table that the directory entry names, and the low twelve bits are the byte offset inside a 4 KB page. The walker makes one memory access at a time through a simple request/acknowledge port. It sets the accessed and dirty bits in the entries it uses by writing each changed entry back.

A client offers a request made of a linear address, a write flag and a user flag. The client may do so while the ready output is high. Exactly one response follows, carrying either a physical address or a page fault with a three-bit cause code. When translation is switched off by the mode input, the address passes through unchanged and memory is not touched. The linear address of the most recent fault stays in a dedicated register for the fault handler.

Entry bits used (both levels): bit 0 present, bit 1 writable, bit 2 user-allowed, bit 5 accessed, bit 6 dirty, bits 31..12 the frame number of the next table or of the page.

Top module: `pgwalk_top`

## Requirements
- R1: With xlat_en_i low, an accepted request produces resp_valid_o one cycle after acceptance, with resp_fault_o low and resp_phys_o equal to the linear address, and no memory access.
- R2: With translation on, the first access is a read at {dir_base_i[31:12], lin[31:22], 2'b00}, using the base value sampled when the request is accepted.
- R3: The page-table read is at {directory entry[31:12], lin[21:12], 2'b00}.
- R4: A successful walk responds with resp_phys_o = {table entry[31:12], lin[11:0]} and resp_fault_o low.
- R5: An entry with bit 0 clear at either level ends the walk with a fault whose code bit 0 is 0, and no further memory access follows that read.
- R6: A user access faults with code bit 0 set when bit 2 is clear at either level. A user write also faults this way when bit 1 is clear at either level. Supervisor accesses are never refused for bits 1 or 2.
- R7: Fault code bit 1 equals the request's write flag and bit 2 equals its user flag.
- R8: A usable directory entry with bit 5 clear is written back with bit 5 set and every other bit unchanged, including bit 6, before the table read. No write-back happens when bit 5 is already set.
- R9: A usable table entry is written back with bit 5 set and, for a write request, bit 6 set. The write-back is skipped when these bits are already set, and faulting entries are never written.
- R10: fault_addr_o resets to 0, shows the faulting linear address from the response cycle of a fault, and keeps its value otherwise.
- R11: Once mem_req_o rises, it stays high with mem_addr_o, mem_we_o and mem_wdata_o stable until the cycle mem_ack_i is seen.
- R12: req_ready_o is high only while no request is in progress. Each accepted request gets exactly one single-cycle resp_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en_i | input | 1 | Translation on (1) or pass-through (0) |
| dir_base_i | input | 32 | Physical base of the page directory, low 12 bits ignored |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle, request taken when valid is also high |
| req_lin_i | input | 32 | Linear address to translate |
| req_write_i | input | 1 | Request is a write |
| req_user_i | input | 1 | Request comes from user level |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_fault_o | output | 1 | Response is a page fault |
| resp_code_o | output | 3 | Fault cause: bit0 protection, bit1 write, bit2 user |
| resp_phys_o | output | 32 | Physical address of a successful response |
| fault_addr_o | output | 32 | Linear address of the last fault |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Entry value to write |
| mem_ack_i | input | 1 | Access complete, read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The embedded properties assume the memory side only raises mem_ack_i while mem_req_o is high and holds it for a single cycle. They also assume the client keeps req_valid_i to one cycle per accepted request. The bench's memory model acknowledges only an outstanding request, drops the acknowledge right after each handshake, and varies its latency between zero and two wait cycles. The client stimulus waits for ready, holds valid for exactly the accepting cycle, and keeps the directory and page tables at distinct addresses, so a write-back never changes an entry that the same walk still has to read.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Entry bit positions shared by both table levels
  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WR_DIR,
    ST_RD_TBL,
    ST_WR_TBL,
    ST_RESP
  } walk_st_e;

  // Packed MSB first: bit2 user, bit1 write, bit0 protection
  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } fcode_t;

endpackage

// File: rtl/pgw_entry_eval.sv
module pgw_entry_eval
  import pgw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic             is_leaf_i,
  input  logic             write_i,
  input  logic             user_i,
  output logic             ok_o,
  output fcode_t           code_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             wb_o
);

  logic present;
  logic deny_user;
  logic deny_write;
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    present    = entry_i[BIT_P];
    deny_user  = user_i & ~entry_i[BIT_US];
    deny_write = user_i & write_i & ~entry_i[BIT_RW];
    ok_o       = present & ~deny_user & ~deny_write;

    code_o.user  = user_i;
    code_o.write = write_i;
    code_o.prot  = present;

    set_mask         = '0;
    set_mask[BIT_A]  = 1'b1;
    set_mask[BIT_D]  = is_leaf_i & write_i;
    upd_o            = entry_i | set_mask;
    wb_o             = (upd_o != entry_i);
  end

endmodule

// File: rtl/pgw_fault_reg.sv
module pgw_fault_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] fault_addr_o
);

  logic [ADDR_W-1:0] fa_q;
  logic [ADDR_W-1:0] fa_n;

  always_comb begin
    fa_n = fa_q;
    if (load_i) fa_n = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fa_q <= '0;
    else        fa_q <= fa_n;
  end

  assign fault_addr_o = fa_q;

  AST_FA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(fault_addr_o)); // R10

  AST_FA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> fault_addr_o == $past(addr_i)); // R10

endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
  import pgw_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10,
  localparam int ADDR_W   = PAGE_BITS + 2 * IDX_BITS,
  localparam int FRAME_W  = ADDR_W - PAGE_BITS,
  localparam int ENT_SH   = PAGE_BITS - IDX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_lin_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [2:0]        resp_code_o,
  output logic [ADDR_W-1:0] resp_phys_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  // entry evaluation results for the word on mem_rdata_i
  output logic              leaf_o,
  output logic              wr_o,
  output logic              usr_o,
  input  logic              ok_i,
  input  fcode_t            code_i,
  input  logic [ADDR_W-1:0] upd_i,
  input  logic              wb_i,
  // fault address capture
  output logic              fa_load_o,
  output logic [ADDR_W-1:0] fa_addr_o
);

  walk_st_e           st_q,    st_n;
  logic [ADDR_W-1:0]  lin_q,   lin_n;
  logic               wr_q,    wr_n;
  logic               usr_q,   usr_n;
  logic [FRAME_W-1:0] base_q,  base_n;
  logic [FRAME_W-1:0] pde_q,   pde_n;
  logic [ADDR_W-1:0]  wb_q,    wb_n;
  logic [ADDR_W-1:0]  phys_q,  phys_n;
  logic               flt_q,   flt_n;
  fcode_t             code_q,  code_n;

  logic [ADDR_W-1:0]  dir_addr;
  logic [ADDR_W-1:0]  tbl_addr;

  assign dir_addr = {base_q, lin_q[ADDR_W-1 -: IDX_BITS], {ENT_SH{1'b0}}};
  assign tbl_addr = {pde_q, lin_q[PAGE_BITS+IDX_BITS-1 -: IDX_BITS], {ENT_SH{1'b0}}};

  // Next-state process
  always_comb begin
    st_n      = st_q;
    lin_n     = lin_q;
    wr_n      = wr_q;
    usr_n     = usr_q;
    base_n    = base_q;
    pde_n     = pde_q;
    wb_n      = wb_q;
    phys_n    = phys_q;
    flt_n     = flt_q;
    code_n    = code_q;
    fa_load_o = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          lin_n  = req_lin_i;
          wr_n   = req_write_i;
          usr_n  = req_user_i;
          base_n = dir_base_i[ADDR_W-1:PAGE_BITS];
          flt_n  = 1'b0;
          code_n = '0;
          if (!xlat_en_i) begin
            phys_n = req_lin_i;
            st_n   = ST_RESP;
          end else begin
            st_n   = ST_RD_DIR;
          end
        end
      end
      ST_RD_DIR: begin
        if (mem_ack_i) begin
          pde_n = mem_rdata_i[ADDR_W-1:PAGE_BITS];
          if (!ok_i) begin
            flt_n     = 1'b1;
            code_n    = code_i;
            fa_load_o = 1'b1;
            st_n      = ST_RESP;
          end else if (wb_i) begin
            wb_n = upd_i;
            st_n = ST_WR_DIR;
          end else begin
            st_n = ST_RD_TBL;
          end
        end
      end
      ST_WR_DIR: begin
        if (mem_ack_i) st_n = ST_RD_TBL;
      end
      ST_RD_TBL: begin
        if (mem_ack_i) begin
          if (!ok_i) begin
            flt_n     = 1'b1;
            code_n    = code_i;
            fa_load_o = 1'b1;
            st_n      = ST_RESP;
          end else begin
            phys_n = {mem_rdata_i[ADDR_W-1:PAGE_BITS], lin_q[PAGE_BITS-1:0]};
            if (wb_i) begin
              wb_n = upd_i;
              st_n = ST_WR_TBL;
            end else begin
              st_n = ST_RESP;
            end
          end
        end
      end
      ST_WR_TBL: begin
        if (mem_ack_i) st_n = ST_RESP;
      end
      ST_RESP: begin
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lin_q  <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      base_q <= '0;
      pde_q  <= '0;
      wb_q   <= '0;
      phys_q <= '0;
      flt_q  <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_n;
      lin_q  <= lin_n;
      wr_q   <= wr_n;
      usr_q  <= usr_n;
      base_q <= base_n;
      pde_q  <= pde_n;
      wb_q   <= wb_n;
      phys_q <= phys_n;
      flt_q  <= flt_n;
      code_q <= code_n;
    end
  end

  // Outputs
  always_comb begin
    req_ready_o  = (st_q == ST_IDLE);
    resp_valid_o = (st_q == ST_RESP);
    resp_fault_o = flt_q;
    resp_code_o  = code_q;
    resp_phys_o  = phys_q;

    mem_req_o   = (st_q == ST_RD_DIR) || (st_q == ST_WR_DIR) ||
                  (st_q == ST_RD_TBL) || (st_q == ST_WR_TBL);
    mem_we_o    = (st_q == ST_WR_DIR) || (st_q == ST_WR_TBL);
    mem_addr_o  = ((st_q == ST_RD_TBL) || (st_q == ST_WR_TBL)) ? tbl_addr : dir_addr;
    mem_wdata_o = wb_q;

    leaf_o    = (st_q == ST_RD_TBL);
    wr_o      = wr_q;
    usr_o     = usr_q;
    fa_addr_o = lin_q;
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o))); // R11

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |=> !resp_valid_o); // R12

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R12

  AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !xlat_en_i) |=> (resp_valid_o && !mem_req_o)); // R1

  AST_SUPER_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_fault_o && !resp_code_o[2]) |-> !resp_code_o[0]); // R6

  AST_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_fault_o) |-> (resp_code_o[1] == wr_q)); // R7

  AST_FAULT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    fa_load_o |=> (resp_valid_o && resp_fault_o && !mem_req_o)); // R5

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10,
  localparam int ADDR_W   = PAGE_BITS + 2 * IDX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_lin_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [2:0]        resp_code_o,
  output logic [ADDR_W-1:0] resp_phys_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);

  logic              leaf;
  logic              wr;
  logic              usr;
  logic              ok;
  fcode_t            code;
  logic [ADDR_W-1:0] upd;
  logic              wb;
  logic              fa_load;
  logic [ADDR_W-1:0] fa_addr;

  pgw_entry_eval #(.ENT_W(ADDR_W)) u_eval (
    .entry_i   (mem_rdata_i),
    .is_leaf_i (leaf),
    .write_i   (wr),
    .user_i    (usr),
    .ok_o      (ok),
    .code_o    (code),
    .upd_o     (upd),
    .wb_o      (wb)
  );

  pgw_walk_fsm #(.PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .xlat_en_i    (xlat_en_i),
    .dir_base_i   (dir_base_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_lin_i    (req_lin_i),
    .req_write_i  (req_write_i),
    .req_user_i   (req_user_i),
    .resp_valid_o (resp_valid_o),
    .resp_fault_o (resp_fault_o),
    .resp_code_o  (resp_code_o),
    .resp_phys_o  (resp_phys_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .leaf_o       (leaf),
    .wr_o         (wr),
    .usr_o        (usr),
    .ok_i         (ok),
    .code_i       (code),
    .upd_i        (upd),
    .wb_i         (wb),
    .fa_load_o    (fa_load),
    .fa_addr_o    (fa_addr)
  );

  pgw_fault_reg #(.ADDR_W(ADDR_W)) u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (fa_load),
    .addr_i       (fa_addr),
    .fault_addr_o (fault_addr_o)
  );

endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        xlat_en_i;
  logic [31:0] dir_base_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [31:0] req_lin_i;
  logic        req_write_i;
  logic        req_user_i;
  logic        resp_valid_o;
  logic        resp_fault_o;
  logic [2:0]  resp_code_o;
  logic [31:0] resp_phys_o;
  logic [31:0] fault_addr_o;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ack_i;
  logic [31:0] mem_rdata_i;

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_en_i(xlat_en_i), .dir_base_i(dir_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_lin_i(req_lin_i),
    .req_write_i(req_write_i), .req_user_i(req_user_i),
    .resp_valid_o(resp_valid_o), .resp_fault_o(resp_fault_o),
    .resp_code_o(resp_code_o), .resp_phys_o(resp_phys_o),
    .fault_addr_o(fault_addr_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory image and expected traffic
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    string       tag;
  } acc_t;

  acc_t        exp_q[$];
  logic [31:0] e_phys;
  logic        e_flt;
  logic [2:0]  e_code;
  string       e_tag;
  logic [31:0] e_fa;
  bit          pending;
  int          lat;
  int          wcnt;
  bit          hold_wait;
  logic [31:0] hold_addr;

  // Behavioural reference of one walk
  task automatic model(input logic en, input logic [31:0] lin,
                       input logic wr, input logic usr);
    logic [31:0] pa, ta, pde, pte, nv;
    acc_t a;
    e_flt = 1'b0;
    e_code = 3'b000;
    if (!en) begin
      e_phys = lin; e_tag = "R1";
      return;
    end
    pa  = {dir_base_i[31:12], lin[31:22], 2'b00};
    pde = rd(pa);
    a.we = 1'b0; a.addr = pa; a.wdata = 32'h0; a.tag = "R2";
    exp_q.push_back(a);
    if (!pde[0]) begin
      e_flt = 1'b1; e_code = {usr, wr, 1'b0}; e_tag = "R5"; e_fa = lin; return;
    end
    if (usr && (!pde[2] || (wr && !pde[1]))) begin
      e_flt = 1'b1; e_code = {usr, wr, 1'b1}; e_tag = "R6"; e_fa = lin; return;
    end
    if (!pde[5]) begin
      a.we = 1'b1; a.addr = pa; a.wdata = pde | 32'h20; a.tag = "R8";
      exp_q.push_back(a);
    end
    ta  = {pde[31:12], lin[21:12], 2'b00};
    pte = rd(ta);
    a.we = 1'b0; a.addr = ta; a.wdata = 32'h0; a.tag = "R3";
    exp_q.push_back(a);
    if (!pte[0]) begin
      e_flt = 1'b1; e_code = {usr, wr, 1'b0}; e_tag = "R5"; e_fa = lin; return;
    end
    if (usr && (!pte[2] || (wr && !pte[1]))) begin
      e_flt = 1'b1; e_code = {usr, wr, 1'b1}; e_tag = "R6"; e_fa = lin; return;
    end
    nv = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (nv != pte) begin
      a.we = 1'b1; a.addr = ta; a.wdata = nv; a.tag = "R9";
      exp_q.push_back(a);
    end
    e_phys = {pte[31:12], lin[11:0]};
    e_tag  = "R4";
  endtask

  // Memory responder and per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack_i = 1'b0;
      wcnt = 0;
      hold_wait = 1'b0;
    end else begin
      if (hold_wait) begin
        chk("R11", "request held", {31'b0, mem_req_o}, 32'h1);
        chk("R11", "address stable", mem_addr_o, hold_addr);
      end
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
        if (wcnt >= lat) begin
          acc_t e;
          wcnt = 0;
          mem_ack_i = 1'b1;
          mem_rdata_i = rd(mem_addr_o);
          if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 R5 unexpected access: actual %h expected none", mem_addr_o);
          end else begin
            e = exp_q.pop_front();
            chk(e.tag, "write flag", {31'b0, mem_we_o}, {31'b0, e.we});
            chk(e.tag, "address", mem_addr_o, e.addr);
            if (e.we) chk(e.tag, "write data", mem_wdata_o, e.wdata);
          end
          if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
        end else begin
          wcnt++;
        end
      end
      hold_wait = mem_req_o && !mem_ack_i;
      hold_addr = mem_addr_o;

      if (resp_valid_o) begin
        if (!pending) begin
          n_cmp++; n_bad++;
          $display("FAIL R12 unexpected response: actual 1 expected 0");
        end else begin
          chk(e_tag, "fault flag", {31'b0, resp_fault_o}, {31'b0, e_flt});
          if (e_flt) begin
            chk("R7", "fault code", {29'b0, resp_code_o}, {29'b0, e_code});
            chk("R10", "fault address", fault_addr_o, e_fa);
          end else begin
            chk(e_tag, "physical address", resp_phys_o, e_phys);
          end
          chk("R5", "accesses left at response", exp_q.size(), 0);
          pending = 1'b0;
        end
      end
    end
  end

  task automatic issue(input logic en, input logic [31:0] lin, input logic wr,
                       input logic usr, input int l);
    int guard;
    @(negedge clk);
    chk("R12", "ready before request", {31'b0, req_ready_o}, 32'h1);
    lat = l;
    xlat_en_i = en;
    req_lin_i = lin;
    req_write_i = wr;
    req_user_i = usr;
    model(en, lin, wr, usr);
    pending = 1'b1;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R12", "busy after accept", {31'b0, req_ready_o}, 32'h0);
    guard = 0;
    while (pending && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (pending) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 no response: actual none expected one");
      pending = 1'b0;
      exp_q.delete();
    end
    @(negedge clk);
    chk("R10", "fault address held", fault_addr_o, e_fa);
  endtask

  initial begin
    rst_n = 1'b0;
    xlat_en_i = 1'b0;
    dir_base_i = 32'h0001_0ABC;
    req_valid_i = 1'b0;
    req_lin_i = '0;
    req_write_i = 1'b0;
    req_user_i = 1'b0;
    mem_rdata_i = '0;
    mem_ack_i = 1'b0;
    pending = 1'b0;
    lat = 0;
    e_fa = 32'h0;

    // directory at 0x10000, tables at 0x20000, 0x40000, 0x60000
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_0004] = 32'h0003_3007;
    mem[32'h0002_0008] = 32'h0000_0000;
    mem[32'h0001_000C] = 32'h0004_0023;
    mem[32'h0004_0000] = 32'h0005_5065;
    mem[32'h0001_0010] = 32'h0006_0027;
    mem[32'h0006_0000] = 32'h0007_7025;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset fault address", fault_addr_o, 32'h0);
    chk("R12", "reset response", {31'b0, resp_valid_o}, 32'h0);
    chk("R11", "reset memory request", {31'b0, mem_req_o}, 32'h0);

    issue(1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1, 0);  // R1 pass-through
    issue(1'b1, 32'h0040_1234, 1'b0, 1'b0, 0);  // R2 R3 R4 R8 R9
    issue(1'b1, 32'h0040_1234, 1'b1, 1'b1, 2);  // R9 dirty set on write
    issue(1'b1, 32'h0040_1FFF, 1'b1, 1'b1, 1);  // R8 R9 no write-back
    issue(1'b1, 32'h0080_0000, 1'b1, 1'b1, 1);  // R5 directory absent
    issue(1'b1, 32'h0040_2000, 1'b0, 1'b0, 0);  // R5 table entry absent
    issue(1'b1, 32'h00C0_0010, 1'b0, 1'b1, 2);  // R6 user blocked at directory
    issue(1'b1, 32'h00C0_0010, 1'b1, 1'b0, 1);  // R6 supervisor write allowed
    issue(1'b1, 32'h00C0_0010, 1'b1, 1'b1, 0);  // R6 R7 user write blocked
    issue(1'b1, 32'h0100_0ABC, 1'b1, 1'b1, 1);  // R6 read-only page, user write
    issue(1'b1, 32'h0100_0ABC, 1'b0, 1'b1, 2);  // R4 user read allowed
    issue(1'b0, 32'h0000_0042, 1'b0, 1'b0, 0);  // R1 R10 register held
    dir_base_i = 32'h0001_0000;
    issue(1'b1, 32'h0100_0001, 1'b0, 1'b0, 0);  // R2 base low bits ignored

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule